// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This unit turns three byte-wide groups of input pins into interrupt requests. Each pin is set up by software through a small byte-wide register bus, in two independent bits. One bit picks level or edge sensitivity. The other picks the active sense: high or rising versus low or falling. In edge mode a qualifying transition sets a sticky per-pin pending flag. Software releases that flag by writing ones to an end-of-interrupt location. In level mode the pending state simply follows the qualified input.

Each pin passes through a two-flop resynchronizer. It can optionally pass through a debounce filter that samples on a prescaled tick. A per-pin enable gates every source, and a status location returns the enabled pending bits of each group. Groups 0 and 1 are merged into one shared request line. Each of the eight pins of group 2 drives a dedicated request line. Both settings are read once per cycle, so changing sense or mode never fabricates an event. Only a transition on the filtered input can create one.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mode, sense, enable and debounce register of every group reads 0, every status reads 0, and `irq_shared` and `irq_line` are low.
- R2: Group bases are 0x90 (group 0), 0xAC (group 1) and 0x4C (group 2). Relative to its base each group has: mode at +0x00, sense at +0x04, end-of-interrupt at +0x08, enable at +0x0C, status at +0x10 (read-only) and debounce at +0x18. Register bit i belongs to pin i. Configuration registers read back what was written, while end-of-interrupt, unmapped addresses and an idle read strobe return 0.
- R3: A pin with mode bit 0 is level-sensitive. It is pending while its qualified input equals its sense bit (1 = high, 0 = low), no state is kept, and an end-of-interrupt write does not change it.
- R4: A pin with mode bit 1 is edge-sensitive. Sense bit 1 selects rising and 0 selects falling. A matching transition sets a pending flag that stays set after the input returns.
- R5: Writing a byte to end-of-interrupt clears the pending edge flag of each pin whose bit is 1 and leaves pins whose bit is 0 untouched.
- R6: When a matching edge and an end-of-interrupt write for the same pin occur in the same cycle, the pin stays pending.
- R7: Status equals pending AND enable. An enable of 0 blanks the pin. Edges that occur while a pin is disabled are not recorded.
- R8: Rewriting the sense or mode bits never creates a pending event by itself. This holds both for the disable, rewrite sense, rewrite mode, re-enable order and for a sense rewrite while enabled; only a later input transition does.
- R9: A pin whose debounce bit is 1 changes its qualified value only after the resynchronized input has differed from it for DB_TICKS consecutive prescaler ticks, one tick every PRESC cycles. Shorter pulses are discarded. A pin whose debounce bit is 0 uses the two-flop resynchronized input.
- R10: `irq_shared` is the OR of all status bits of groups 0 and 1. `irq_line[i]` is status bit i of group 2, and group 2 has no effect on `irq_shared`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when `bus_rd` is low |
| pin_p0 | input | 8 | Group 0 pin inputs |
| pin_p1 | input | 8 | Group 1 pin inputs |
| pin_p2 | input | 8 | Group 2 pin inputs |
| irq_shared | output | 1 | Combined request of groups 0 and 1 |
| irq_line | output | 8 | Per-pin requests of group 2 |

## Verification
The hardest case to produce is an edge detection that falls in exactly the cycle in which software writes end-of-interrupt for the same pin. The bench first leaves the pin pending. It then changes the input on a falling clock edge, counts the two resynchronizer stages, and issues the write so that it is captured on the very edge that records the new transition. Debounce boundaries get similar treatment: pulses are timed to cover fewer prescaler ticks than the threshold, and held inputs are timed to cover more.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int NPORT = 3;
  localparam int PW    = 8;
  localparam int AW    = 8;

  localparam logic [AW-1:0] OFS_MODE = 8'h00;
  localparam logic [AW-1:0] OFS_POL  = 8'h04;
  localparam logic [AW-1:0] OFS_EOI  = 8'h08;
  localparam logic [AW-1:0] OFS_EN   = 8'h0C;
  localparam logic [AW-1:0] OFS_STAT = 8'h10;
  localparam logic [AW-1:0] OFS_DB   = 8'h18;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_MODE, FLD_POL, FLD_EOI, FLD_EN, FLD_STAT, FLD_DB
  } fld_e;

  function automatic logic [AW-1:0] group_base(input int g);
    case (g)
      0:       return 8'h90;
      1:       return 8'hAC;
      default: return 8'h4C;
    endcase
  endfunction

  function automatic fld_e decode_field(input logic [AW-1:0] addr,
                                        input logic [AW-1:0] base);
    logic [AW-1:0] rel;
    rel = addr - base;
    case (rel)
      OFS_MODE: return FLD_MODE;
      OFS_POL:  return FLD_POL;
      OFS_EOI:  return FLD_EOI;
      OFS_EN:   return FLD_EN;
      OFS_STAT: return FLD_STAT;
      OFS_DB:   return FLD_DB;
      default:  return FLD_NONE;
    endcase
  endfunction

  // level source active when the input equals the sense bit
  function automatic logic [PW-1:0] level_match(input logic [PW-1:0] cur,
                                                input logic [PW-1:0] sense);
    return ~(cur ^ sense);
  endfunction

  // rising where sense is 1, falling where sense is 0
  function automatic logic [PW-1:0] edge_match(input logic [PW-1:0] cur,
                                               input logic [PW-1:0] prev,
                                               input logic [PW-1:0] sense);
    return (cur & ~prev & sense) | (~cur & prev & ~sense);
  endfunction

endpackage

// File: rtl/gpio_db_filter.sv
module gpio_db_filter #(
  parameter int DB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic db_en,
  input  logic raw,
  output logic q
);
  localparam int CW = $clog2(DB_TICKS + 1);

  logic          s1_q, s2_q, filt_q;
  logic [CW-1:0] cnt_q;
  logic          differs;
  logic          settle;

  assign differs = (s2_q != filt_q);
  assign settle  = db_en && differs && tick && (cnt_q == CW'(DB_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!db_en) begin
      filt_q <= s2_q;
      cnt_q  <= '0;
    end else if (!differs) begin
      cnt_q  <= '0;
    end else if (settle) begin
      filt_q <= s2_q;
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign q = db_en ? filt_q : s2_q;

  // R9: with filtering on, the filtered value moves only on a sample tick
  a_r9_db_moves_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && $past(db_en) && (filt_q != $past(filt_q))) |-> $past(tick));

  // R9: the counter never passes the threshold
  a_r9_cnt_bounded : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(DB_TICKS));

endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpio_irq_pkg::*;
#(
  parameter int DB_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] pins,
  input  logic [PW-1:0] wdata,
  input  logic          wr_mode,
  input  logic          wr_pol,
  input  logic          wr_eoi,
  input  logic          wr_en,
  input  logic          wr_db,
  output logic [PW-1:0] mode_q,
  output logic [PW-1:0] pol_q,
  output logic [PW-1:0] en_q,
  output logic [PW-1:0] db_q,
  output logic [PW-1:0] stat
);
  logic [PW-1:0] qual;
  logic [PW-1:0] prev_q;
  logic [PW-1:0] latch_q;
  logic [PW-1:0] edge_hit;
  logic [PW-1:0] eoi_mask;
  logic [PW-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      db_q   <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      if (wr_en)   en_q   <= wdata;
      if (wr_db)   db_q   <= wdata;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_pin
    gpio_db_filter #(.DB_TICKS(DB_TICKS)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .db_en (db_q[i]),
      .raw   (pins[i]),
      .q     (qual[i])
    );
  end

  assign edge_hit = mode_q & en_q & edge_match(qual, prev_q, pol_q);
  assign eoi_mask = wr_eoi ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= qual;
      latch_q <= mode_q & ((latch_q & ~eoi_mask) | edge_hit);
    end
  end

  assign pend = (mode_q & latch_q) | (~mode_q & level_match(qual, pol_q));
  assign stat = pend & en_q;

  // R5: an end-of-interrupt bit clears its latch unless an edge arrives
  a_r5_eoi_clears : assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi |=> ((latch_q & $past(wdata & ~edge_hit)) == '0));

  // R6: a detected edge is always recorded on the next edge
  a_r6_edge_wins : assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

  // R7: a disabled pin never arms its latch
  a_r7_no_arm_disabled : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(en_q)) == '0));

  // R3: level-mode pins hold no latched state
  a_r3_level_no_latch : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(mode_q)) == '0));

  // R8: with a steady qualified input no latch can rise
  a_r8_no_false_event : assert property (@(posedge clk) disable iff (!rst_n)
    (qual == prev_q) |=> ((latch_q & ~$past(latch_q)) == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int PRESC    = 4,
  parameter int DB_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  input  logic [PW-1:0] pin_p0,
  input  logic [PW-1:0] pin_p1,
  input  logic [PW-1:0] pin_p2,
  output logic          irq_shared,
  output logic [PW-1:0] irq_line
);
  localparam int PCW = $clog2(PRESC + 1);

  logic [PCW-1:0] pcnt_q;
  logic           tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt_q <= '0;
    else if (tick)  pcnt_q <= '0;
    else            pcnt_q <= pcnt_q + PCW'(1);
  end
  assign tick = (pcnt_q == PCW'(PRESC - 1));

  logic [PW-1:0] pins_a [NPORT];
  logic [PW-1:0] mode_a [NPORT];
  logic [PW-1:0] pol_a  [NPORT];
  logic [PW-1:0] en_a   [NPORT];
  logic [PW-1:0] db_a   [NPORT];
  logic [PW-1:0] stat_a [NPORT];
  fld_e          fld    [NPORT];

  assign pins_a[0] = pin_p0;
  assign pins_a[1] = pin_p1;
  assign pins_a[2] = pin_p2;

  for (genvar g = 0; g < NPORT; g++) begin : g_grp
    assign fld[g] = decode_field(bus_addr, group_base(g));

    gpio_port_core #(.DB_TICKS(DB_TICKS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pins    (pins_a[g]),
      .wdata   (bus_wdata),
      .wr_mode (bus_wr && (fld[g] == FLD_MODE)),
      .wr_pol  (bus_wr && (fld[g] == FLD_POL)),
      .wr_eoi  (bus_wr && (fld[g] == FLD_EOI)),
      .wr_en   (bus_wr && (fld[g] == FLD_EN)),
      .wr_db   (bus_wr && (fld[g] == FLD_DB)),
      .mode_q  (mode_a[g]),
      .pol_q   (pol_a[g]),
      .en_q    (en_a[g]),
      .db_q    (db_a[g]),
      .stat    (stat_a[g])
    );
  end

  logic [PW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NPORT; g++) begin
      case (fld[g])
        FLD_MODE: rd_mux = rd_mux | mode_a[g];
        FLD_POL:  rd_mux = rd_mux | pol_a[g];
        FLD_EN:   rd_mux = rd_mux | en_a[g];
        FLD_STAT: rd_mux = rd_mux | stat_a[g];
        FLD_DB:   rd_mux = rd_mux | db_a[g];
        default:  rd_mux = rd_mux;
      endcase
    end
  end

  assign bus_rdata  = bus_rd ? rd_mux : '0;
  assign irq_shared = |(stat_a[0] | stat_a[1]);
  assign irq_line   = stat_a[2];

  // R7: a request line of group 2 is only raised for an enabled pin
  a_r7_line_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & ~en_a[2]) == '0));

  // R9: the prescaler tick repeats and never runs past its period
  a_r9_tick_period : assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < PCW'(PRESC));

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_p0 = '0, pin_p1 = '0, pin_p2 = '0;
  logic       irq_shared;
  logic [7:0] irq_line;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] B0 = 8'h90, B1 = 8'hAC, B2 = 8'h4C;
  localparam logic [7:0] MODE = 8'h00, POL = 8'h04, EOI = 8'h08,
                         EN = 8'h0C, STAT = 8'h10, DB = 8'h18;

  always #2 clk = ~clk;

  gpio_irq_unit #(.PRESC(4), .DB_TICKS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_p0(pin_p0), .pin_p1(pin_p1), .pin_p2(pin_p2),
    .irq_shared(irq_shared), .irq_line(irq_line));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0; bus_addr = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [7:0] bases [3];
    bases[0] = B0; bases[1] = B1; bases[2] = B2;
    for (int g = 0; g < 3; g++) begin
      rd(bases[g] + MODE, d); chk("R1 mode", d, 8'h00);
      rd(bases[g] + POL,  d); chk("R1 sense", d, 8'h00);
      rd(bases[g] + EN,   d); chk("R1 enable", d, 8'h00);
      rd(bases[g] + DB,   d); chk("R1 debounce", d, 8'h00);
      rd(bases[g] + STAT, d); chk("R1 status", d, 8'h00);
    end
    chk("R1 irq_shared", {7'd0, irq_shared}, 8'h00);
    chk("R1 irq_line", irq_line, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(B0 + POL, 8'hF0); wr(B0 + MODE, 8'h00); wr(B0 + EN, 8'hFF);
    pin_p0 = 8'h3C; cyc(4);
    rd(B0 + STAT, d); chk("R3 level status", d, 8'h33);
    chk("R10 shared from group 0", {7'd0, irq_shared}, 8'h01);
    wr(B0 + EOI, 8'hFF); cyc(1);
    rd(B0 + STAT, d); chk("R5 eoi ignored in level mode", d, 8'h33);
    wr(B0 + EN, 8'h00); cyc(1);
    rd(B0 + STAT, d); chk("R7 enable zero blanks", d, 8'h00);
    chk("R7 shared low when disabled", {7'd0, irq_shared}, 8'h00);
    pin_p0 = 8'h00; wr(B0 + POL, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr(B1 + MODE, 8'hFF); wr(B1 + POL, 8'h0F); wr(B1 + EN, 8'hFF);
    cyc(5);
    rd(B1 + STAT, d); chk("R4 no event without transition", d, 8'h00);
    pin_p1 = 8'hFF; cyc(5);
    rd(B1 + STAT, d); chk("R4 rising on low nibble", d, 8'h0F);
    chk("R10 shared from group 1", {7'd0, irq_shared}, 8'h01);
    pin_p1 = 8'h00; cyc(5);
    rd(B1 + STAT, d); chk("R4 sticky plus falling", d, 8'hFF);
    wr(B1 + EOI, 8'h05); cyc(1);
    rd(B1 + STAT, d); chk("R5 partial clear", d, 8'hFA);
    wr(B1 + EOI, 8'hFA); cyc(1);
    rd(B1 + STAT, d); chk("R5 full clear", d, 8'h00);
    chk("R10 shared drops", {7'd0, irq_shared}, 8'h00);
  endtask

  task automatic t_lines;
    logic [7:0] d;
    wr(B2 + MODE, 8'hFF); wr(B2 + POL, 8'h00); wr(B2 + EN, 8'h81);
    pin_p2 = 8'hFF; cyc(5);
    chk("R4 rising ignored in falling mode", irq_line, 8'h00);
    pin_p2 = 8'h00; cyc(5);
    chk("R10 per-pin lines", irq_line, 8'h81);
    rd(B2 + STAT, d); chk("R7 group 2 status gated", d, 8'h81);
    chk("R10 group 2 not shared", {7'd0, irq_shared}, 8'h00);
    wr(B2 + EOI, 8'h81); cyc(1);
    chk("R5 lines cleared", irq_line, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    pin_p1 = 8'h01; cyc(5);
    rd(B1 + STAT, d); chk("R4 bit0 pending", d, 8'h01);
    pin_p1 = 8'h00; cyc(5);
    @(negedge clk); pin_p1 = 8'h01;
    @(posedge clk); @(posedge clk);
    wr(B1 + EOI, 8'h01); cyc(1);
    rd(B1 + STAT, d); chk("R6 edge beats eoi", d, 8'h01);
    wr(B1 + EOI, 8'h01); cyc(1);
    rd(B1 + STAT, d); chk("R6 later eoi clears", d, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(B1 + EN, 8'h00);
    pin_p1 = 8'h00; cyc(5);
    pin_p1 = 8'h0F; cyc(5);
    wr(B1 + EN, 8'hFF); cyc(1);
    rd(B1 + STAT, d); chk("R7 edge while disabled dropped", d, 8'h00);
    pin_p1 = 8'h00; cyc(5);
    pin_p1 = 8'h0F; cyc(5);
    rd(B1 + STAT, d); chk("R7 edge after enable kept", d, 8'h0F);
    wr(B1 + EOI, 8'hFF);
  endtask

  task automatic t_reorder;
    logic [7:0] d;
    wr(B1 + EN, 8'h00); wr(B1 + POL, 8'h00); wr(B1 + MODE, 8'hFF);
    wr(B1 + EN, 8'hFF); cyc(5);
    rd(B1 + STAT, d); chk("R8 ordered rewrite silent", d, 8'h00);
    pin_p1 = 8'h00; cyc(5);
    rd(B1 + STAT, d); chk("R8 falling after rewrite", d, 8'h0F);
    wr(B1 + EOI, 8'hFF);
    wr(B1 + POL, 8'h0F); cyc(5);
    rd(B1 + STAT, d); chk("R8 live sense rewrite silent", d, 8'h00);
    wr(B1 + MODE, 8'h00); wr(B1 + POL, 8'h00); wr(B1 + EN, 8'h00);
    wr(B1 + MODE, 8'hFF); wr(B1 + EN, 8'hFF); cyc(5);
    rd(B1 + STAT, d); chk("R8 level to edge silent", d, 8'h00);
    wr(B1 + EN, 8'h00);
  endtask

  task automatic t_debounce;
    logic [7:0] d;
    wr(B0 + MODE, 8'h00); wr(B0 + POL, 8'hFF); wr(B0 + DB, 8'h01);
    wr(B0 + EN, 8'h03);
    @(negedge clk); pin_p0 = 8'h01;
    repeat (8) @(negedge clk);
    pin_p0 = 8'h00; cyc(20);
    rd(B0 + STAT, d); chk("R9 short pulse rejected", d, 8'h00);
    @(negedge clk); pin_p0 = 8'h01;
    repeat (8) @(negedge clk);
    chk("R9 not yet settled", {7'd0, irq_shared}, 8'h00);
    cyc(30);
    rd(B0 + STAT, d); chk("R9 held input accepted", d, 8'h01);
    pin_p0 = 8'h03; cyc(3);
    rd(B0 + STAT, d); chk("R9 unfiltered pin fast", d, 8'h03);
    pin_p0 = 8'h00; cyc(3);
    rd(B0 + STAT, d); chk("R9 filtered pin still held", d, 8'h01);
    cyc(30);
    rd(B0 + STAT, d); chk("R9 filtered release", d, 8'h00);
    wr(B0 + EN, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(B2 + DB, 8'hA5);
    rd(B2 + DB, d);   chk("R2 debounce readback", d, 8'hA5);
    rd(B2 + MODE, d); chk("R2 mode readback", d, 8'hFF);
    rd(B2 + EN, d);   chk("R2 enable readback", d, 8'h81);
    rd(B0 + POL, d);  chk("R2 sense readback", d, 8'hFF);
    rd(B2 + EOI, d);  chk("R2 eoi reads zero", d, 8'h00);
    rd(8'hA4, d);     chk("R2 unmapped reads zero", d, 8'h00);
    wr(B1 + STAT, 8'hFF);
    rd(B1 + STAT, d); chk("R2 status read-only", d, 8'h00);
    bus_addr = B2 + DB; #1;
    chk("R2 idle strobe zero", bus_rdata, 8'h00);
    bus_addr = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_level();
    t_edge();
    t_lines();
    t_race();
    t_disabled();
    t_reorder();
    t_debounce();
    t_readback();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule